// File: doc/BRIEF.md
# Screen line read-back controller

This controller is a test aid for a character terminal. When a hardware test strap holds it armed, a received BEL control byte (0x07) makes it stream the top line of the display back out. It starts at the current cursor column and runs through the last column inclusive. Each character is fetched from display memory through a synchronous read port with one cycle of latency. The character is then offered on a ready/valid transmit interface. Each accepted character except the last advances the cursor. The cursor therefore ends on the final column of the line, and a one-cycle roll request then asks the display logic to scroll by one line without blanking anything.

The cursor column register and the display memory sit outside the block. The controller reads the column, drives the memory address from it and pulses an increment strobe. The reset input clears all control state. It is asserted asynchronously and released through a synchronizer. Display memory is not touched.

Top module: `screen_readback`

## Requirements
- R1: While reset is asserted, and until a BEL is taken after its release, `active`, `tx_valid`, `cur_inc` and `roll` are all 0. An assertion of reset in the middle of a transfer drops them at once.
- R2: When `strap_n` is 1 (feature disarmed), a received BEL is ignored: nothing is sent, the cursor does not move and no roll is issued.
- R3: When `strap_n` is 0, a byte with `rx_valid` = 1 and `rx_data` = 8'h07 starts a transfer. Any other byte value is ignored.
- R4: A transfer sends, in ascending order, the memory byte of every column from the starting cursor column up to column COLS-1 inclusive. With COLS = 80 and a start at column c < 79, that is 80-c bytes.
- R5: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` stays 1 and `tx_data` stays unchanged on the next cycle.
- R6: `cur_inc` pulses for one cycle on each accepted byte whose column is below COLS-1, and never otherwise. The cursor ends on column COLS-1.
- R7: The handshake on the last column ends the transfer. `active` is 0 in the next cycle, and `roll` is 1 for exactly that one cycle.
- R8: A BEL received while a transfer is in progress has no effect. The transfer still sends exactly the same bytes and issues one roll.
- R9: A transfer started with the cursor at or beyond column COLS-1 sends exactly one byte, from that column, with no cursor increment, and then rolls.
- R10: The first `tx_valid` appears two cycles after the clock edge that takes the BEL. Cycle one presents the address and cycle two presents the data.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Clear, asynchronous assert, active low |
| strap_n | input | 1 | Test strap, 0 arms the feature |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| cur_col | input | 7 | Current cursor column |
| cur_inc | output | 1 | Cursor increment strobe |
| mem_addr | output | 7 | Display memory column address, top line |
| mem_data | input | 8 | Display memory read data, one cycle after address |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmitter accepts byte |
| tx_data | output | 8 | Transmit byte |
| roll | output | 1 | One-cycle request to roll screen one line |
| active | output | 1 | Read-back in progress |

## Verification
The bench starts transfers at column 0, in mid-line, on the last column and beyond it, and checks every byte against the memory model. A design with an off-by-one end test would drop or repeat the last column, or would let the cursor wrap to zero. Scenarios with a stalling transmitter catch a design that advances past a byte that was never accepted. A second BEL injected mid-transfer and a BEL with the strap high catch a design that restarts or arms when it should not. A reset in the middle of a transfer catches state that survives the clear.

// File: rtl/rb_pkg.sv
package rb_pkg;
  typedef enum logic [1:0] {
    RB_IDLE = 2'd0,
    RB_READ = 2'd1,
    RB_SEND = 2'd2
  } rb_state_t;
endpackage

// File: rtl/rb_rst_sync.sv
// Reset synchronizer: asserts asynchronously, releases after STAGES edges.
module rb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rb_bel_detect.sv
// Decodes the trigger byte, gated by the active-low test strap.
module rb_bel_detect #(
  parameter int              DATA_W = 8,
  parameter logic [DATA_W-1:0] CODE = 8'h07
) (
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              strap_n,
  output logic              hit
);
  always_comb begin
    hit = rx_valid && (rx_data == CODE) && !strap_n;
  end
endmodule

// File: rtl/rb_ctrl.sv
// Sequencer: address phase, data phase, handshake, cursor step or finish.
module rb_ctrl
  import rb_pkg::*;
#(
  parameter int COLS  = 80,
  parameter int COL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [COL_W-1:0] cur_col,
  input  logic             tx_ready,
  output logic             active,
  output logic             tx_valid,
  output logic             cur_inc,
  output logic             done,
  output logic [COL_W-1:0] mem_addr
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

  rb_state_t state_q, state_d;
  logic      at_end;
  logic      take;

  always_comb begin
    at_end  = (cur_col >= LAST_COL);
    take    = (state_q == RB_SEND) && tx_ready;
    state_d = state_q;
    done    = 1'b0;
    cur_inc = 1'b0;
    unique case (state_q)
      RB_IDLE: if (hit) state_d = RB_READ;
      RB_READ: state_d = RB_SEND;
      RB_SEND: begin
        if (take) begin
          if (at_end) begin
            done    = 1'b1;
            state_d = RB_IDLE;
          end else begin
            cur_inc = 1'b1;
            state_d = RB_READ;
          end
        end
      end
      default: state_d = RB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RB_IDLE;
    else        state_q <= state_d;
  end

  assign active   = (state_q != RB_IDLE);
  assign tx_valid = (state_q == RB_SEND);
  assign mem_addr = cur_col;
endmodule

// File: rtl/rb_roll_gen.sv
// Registers the finish event into a one-cycle roll request.
module rb_roll_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  output logic roll
);
  logic roll_q, roll_d;

  always_comb roll_d = done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) roll_q <= 1'b0;
    else        roll_q <= roll_d;
  end

  assign roll = roll_q;
endmodule

// File: rtl/screen_readback.sv
module screen_readback #(
  parameter int COLS   = 80,
  parameter int COL_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [COL_W-1:0]  cur_col,
  output logic              cur_inc,
  output logic [COL_W-1:0]  mem_addr,
  input  logic [DATA_W-1:0] mem_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              roll,
  output logic              active
);
  logic rst_int_n;
  logic hit;
  logic done;

  rb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  rb_bel_detect #(.DATA_W(DATA_W), .CODE(DATA_W'(7))) u_bel (
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .strap_n  (strap_n),
    .hit      (hit)
  );

  rb_ctrl #(.COLS(COLS), .COL_W(COL_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .hit      (hit),
    .cur_col  (cur_col),
    .tx_ready (tx_ready),
    .active   (active),
    .tx_valid (tx_valid),
    .cur_inc  (cur_inc),
    .done     (done),
    .mem_addr (mem_addr)
  );

  rb_roll_gen u_roll (
    .clk   (clk),
    .rst_n (rst_int_n),
    .done  (done),
    .roll  (roll)
  );

  // Memory output is held while the address is held, so it feeds the link directly.
  assign tx_data = mem_data;
endmodule

// File: rtl/rb_checker.sv
module rb_checker #(
  parameter int COLS   = 80,
  parameter int COL_W  = 7,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strap_n,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic [COL_W-1:0]  cur_col,
  input logic              cur_inc,
  input logic [COL_W-1:0]  mem_addr,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              roll,
  input logic              active
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

  // R2
  p_strap_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && strap_n) |=> !active);

  // R5
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(mem_addr)));

  // R6
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cur_inc |-> (cur_col < LAST_COL));

  p_inc_on_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cur_inc |-> (tx_valid && tx_ready));

  // R7
  p_roll_after_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    roll |-> (!active && $past(tx_valid && tx_ready)));

  p_roll_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    roll |=> !roll);

  // R10
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && rx_valid && (rx_data == DATA_W'(7)) && !strap_n && $past(rst_n))
      |=> (active && !tx_valid) ##1 tx_valid);
endmodule

bind screen_readback rb_checker #(.COLS(COLS), .COL_W(COL_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .strap_n  (strap_n),
  .rx_valid (rx_valid),
  .rx_data  (rx_data),
  .cur_col  (cur_col),
  .cur_inc  (cur_inc),
  .mem_addr (mem_addr),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .roll     (roll),
  .active   (active)
);

// File: tb/screen_readback_test.sv
module screen_readback_test;
  localparam int CLK_PERIOD = 10;
  localparam int COLS = 80;

  // {start col[31:24], flags[23:20] (bit0 strap_n, bit1 inject BEL), stall[19:16], code[15:8], expected bytes[7:0]}
  localparam logic [31:0] VEC [8] = '{
    32'h00000750, 32'h4B010705, 32'h4F000701, 32'h64000701,
    32'h0A100700, 32'h0A000800, 32'h28010728, 32'h4620070A
  };

  logic       clk = 1'b0;
  logic       rst_n, strap_n, rx_valid, tx_ready;
  logic [7:0] rx_data, mem_q, tx_data;
  logic [6:0] cur_q, mem_addr, load_val;
  logic       load_en, cur_inc, tx_valid, roll, active;
  int         errors = 0;
  int         checks = 0;
  bit         finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  screen_readback uut (
    .clk(clk), .rst_n(rst_n), .strap_n(strap_n), .rx_valid(rx_valid),
    .rx_data(rx_data), .cur_col(cur_q), .cur_inc(cur_inc), .mem_addr(mem_addr),
    .mem_data(mem_q), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .roll(roll), .active(active)
  );

  function automatic logic [7:0] ramval(input int a);
    return 8'((a * 7) + 3);
  endfunction

  // External cursor register and synchronous display memory models.
  always_ff @(posedge clk) begin
    if (load_en)      cur_q <= load_val;
    else if (cur_inc) cur_q <= cur_q + 7'd1;
    mem_q <= ramval(int'(mem_addr));
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_scn(input int start, input logic [3:0] flags, input logic stall,
                         input logic [7:0] code, input int exp_n);
    int got = 0, rolls = 0, first = -1, exp_cur;
    bit pend = 0;
    logic [7:0] pdata = 8'h00;
    bit rdy;
    @(negedge clk); load_en = 1'b1; load_val = 7'(start); tx_ready = 1'b1;
    @(negedge clk); load_en = 1'b0; rx_valid = 1'b1; rx_data = code; strap_n = flags[0];
    @(negedge clk); rx_valid = 1'b0; rx_data = 8'h00;
    for (int c = 0; c < 400; c++) begin
      if (c > 0) @(negedge clk);
      if (flags[1] && c == 5) begin rx_valid = 1'b1; rx_data = 8'h07; end
      else rx_valid = 1'b0;
      rdy = stall ? ((c % 3) != 1) : 1'b1;
      tx_ready = rdy;
      if (roll) rolls++;
      if (pend) chk(tx_valid && tx_data == pdata, "R5", "held byte under stall", int'(tx_data), int'(pdata));
      if (tx_valid && first < 0) first = c;
      if (tx_valid && rdy) begin
        chk(tx_data == ramval(start + got), "R4", "byte value", int'(tx_data), int'(ramval(start + got)));
        got++;
      end
      pend  = tx_valid && !rdy;
      pdata = tx_data;
      if (!active && c >= 2) break;
    end
    rx_valid = 1'b0; tx_ready = 1'b1;
    exp_cur = (exp_n == 0 || start >= COLS - 1) ? start : COLS - 1;
    chk(got == exp_n, (exp_n == 0) ? "R2/R3" : "R4", "byte count", got, exp_n);
    chk(rolls == ((exp_n > 0) ? 1 : 0), "R7", "roll pulses", rolls, (exp_n > 0) ? 1 : 0);
    chk(int'(cur_q) == exp_cur, "R6", "final cursor", int'(cur_q), exp_cur);
    chk(!active, "R7", "flag cleared", int'(active), 0);
    if (exp_n > 0) chk(first == 1, "R10", "first valid cycle", first, 1);
    if (start >= COLS - 1 && exp_n > 0) chk(got == 1, "R9", "single byte at end", got, 1);
    if (flags[1]) chk(got == exp_n && rolls == 1, "R8", "mid BEL ignored", got, exp_n);
  endtask

  initial begin
    rst_n = 1'b0; strap_n = 1'b0; rx_valid = 1'b0; rx_data = 8'h00;
    tx_ready = 1'b1; load_en = 1'b1; load_val = 7'd0;
    repeat (3) @(negedge clk);
    chk(!active && !tx_valid && !cur_inc && !roll, "R1", "outputs in reset", int'(active), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    load_en = 1'b0;
    chk(!active && !tx_valid && !roll, "R1", "idle after release", int'(tx_valid), 0);

    foreach (VEC[i]) begin
      run_scn(int'(VEC[i][31:24]), VEC[i][23:20], VEC[i][16], VEC[i][15:8], int'(VEC[i][7:0]));
    end

    // Directed: reset in the middle of a transfer (R1).
    @(negedge clk); load_en = 1'b1; load_val = 7'd0;
    @(negedge clk); load_en = 1'b0; rx_valid = 1'b1; rx_data = 8'h07; strap_n = 1'b0;
    @(negedge clk); rx_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(active, "R3", "transfer running", int'(active), 1);
    rst_n = 1'b0;
    #1;
    chk(!active && !tx_valid && !cur_inc && !roll, "R1", "mid-transfer clear", int'(active), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!active && !tx_valid, "R1", "stays idle after clear", int'(active), 0);

    // Directed: end-of-line start after clear (R9).
    run_scn(78, 4'h0, 1'b1, 8'h07, 2);
    run_scn(79, 4'h0, 1'b1, 8'h07, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule